// File: doc/BRIEF.md
# DDR 1:4 Input Deserializer with Split-Phase Enable

This block turns a serial input stream into 4-bit parallel words. The stream is sampled on both edges of a fast bit clock. The design sees that clock as two rising-edge clocks: `fast_clk` and its logical complement `fast_clk_n`. A divided clock `div_clk` runs at half the fast-clock frequency. It frames each group of four bit-times and loads the finished word into the output register on every rising edge. The block is meant for the read path of a bidirectional memory-style interface. On such a path, capture must be switched off for parts of a word while the bus turns around.

A parameter `EN_COUNT` selects the enable scheme. With one enable, `en_early` gates every sampling register directly. With two enables, each enable is registered on `div_clk`. The registered `en_early` then governs the half of the divided period in which `div_clk` is high, and the registered `en_late` governs the low half. A sampling register whose enable is off keeps its old value, and that value appears again in the next word. The output register has no enable and loads on every divided-clock edge.

The divided clock must rise between a rising edge and a falling edge of `fast_clk`. Each half of its period then holds exactly one falling edge followed by one rising edge.

Top module: `ddr_deser`

## Requirements
- R1: Every rising edge of `div_clk` loads `par_out` with the four bits sampled since the previous rising edge, in arrival order. Bit 0 holds the earliest bit and bit 3 the latest.
- R2: Within one divided period, bits are sampled at four edges in this order: a `fast_clk_n` rising edge and then a `fast_clk` rising edge while `div_clk` is high (bits 0 and 1), then the same pair while `div_clk` is low (bits 2 and 3).
- R3: With `EN_COUNT` = 1, `en_early` is an active-high enable applied combinationally to all four sampling registers. `en_late` has no effect on `par_out`.
- R4: With `EN_COUNT` = 2, `en_early` and `en_late` are captured on each `div_clk` rising edge. The captured `en_early` gates bits 0 and 1 of the word that is being gathered, and the captured `en_late` gates bits 2 and 3.
- R5: A sampling register whose enable is low at its sampling edge keeps its previous value. The held bit then appears in the next word at the same position.
- R6: The output register has no enable. A new word is loaded on every `div_clk` rising edge, whatever the enables are.
- R7: Asserting `rst` clears the enable registers, the sampling registers and `par_out` to zero at once, without waiting for a clock edge.
- R8: With `EN_COUNT` = 2, a change on `en_early` made after a `div_clk` rising edge does not affect the word gathered in that divided period. With `EN_COUNT` = 1 the same change takes effect at the next sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Fast bit clock; samples bits 1 and 3 on its rising edge |
| fast_clk_n | input | 1 | Logical complement of `fast_clk`; samples bits 0 and 2 on its rising edge |
| div_clk | input | 1 | Divided clock at half the `fast_clk` rate; frames words and loads `par_out` |
| rst | input | 1 | Asynchronous active-high reset |
| ser_in | input | 1 | Serial data input |
| en_early | input | 1 | Sole enable (one-enable mode) or enable for the `div_clk`-high half (two-enable mode) |
| en_late | input | 1 | Enable for the `div_clk`-low half (two-enable mode); unused otherwise |
| par_out | output | 4 | Parallel word, earliest bit in bit 0 |

## Verification
On every fast-clock edge, assertions check that a sampling register whose gate is low at that edge keeps its value, for each of the four bit slots. They also check that `par_out` is zero while reset is held. Other behaviours can only be shown by the bench's scenarios, which run both enable variants side by side. These are the bit order within a word, the one-period delay before a registered enable takes effect, the fact that `en_late` does nothing in one-enable mode, and held bits reappearing in later words.

// File: rtl/ddr_deser_pkg.sv
`timescale 1ns/1ps
package ddr_deser_pkg;
    localparam int WORD_W     = 4;
    localparam int HALF_SLOTS = WORD_W / 2;

    typedef struct packed {
        logic early;
        logic late;
    } en_pair_t;

    typedef struct packed {
        logic hi_half;
        logic lo_half;
    } edge_pair_t;
endpackage

// File: rtl/ddr_deser_enable.sv
`timescale 1ns/1ps
module ddr_deser_enable
    import ddr_deser_pkg::*;
#(
    parameter int EN_COUNT = 2
) (
    input  logic div_clk,
    input  logic rst,
    input  logic en_early,
    input  logic en_late,
    output logic gate
);
    generate
        if (EN_COUNT == 1) begin : g_single
            logic unused_late;
            assign unused_late = en_late;
            always_comb gate = en_early;
        end else begin : g_split
            en_pair_t en_d, en_q;

            always_comb begin
                en_d       = en_q;
                en_d.early = en_early;
                en_d.late  = en_late;
            end

            always_ff @(posedge div_clk or posedge rst) begin
                if (rst) en_q <= '0;
                else     en_q <= en_d;
            end

            // high half of the divided period follows the early enable
            always_comb gate = div_clk ? en_q.early : en_q.late;
        end
    endgenerate
endmodule

// File: rtl/ddr_deser_capture.sv
`timescale 1ns/1ps
module ddr_deser_capture
    import ddr_deser_pkg::*;
(
    input  logic              fast_clk,
    input  logic              fast_clk_n,
    input  logic              div_clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              gate,
    output logic [WORD_W-1:0] slots
);
    edge_pair_t rise_d, rise_q;
    edge_pair_t fall_d, fall_q;

    // rising edge of fast_clk: bits 1 and 3
    always_comb begin
        rise_d = rise_q;
        if (gate) begin
            if (div_clk) rise_d.hi_half = ser_in;
            else         rise_d.lo_half = ser_in;
        end
    end

    // rising edge of fast_clk_n (falling edge of fast_clk): bits 0 and 2
    always_comb begin
        fall_d = fall_q;
        if (gate) begin
            if (div_clk) fall_d.hi_half = ser_in;
            else         fall_d.lo_half = ser_in;
        end
    end

    always_ff @(posedge fast_clk or posedge rst) begin
        if (rst) rise_q <= '0;
        else     rise_q <= rise_d;
    end

    always_ff @(posedge fast_clk_n or posedge rst) begin
        if (rst) fall_q <= '0;
        else     fall_q <= fall_d;
    end

    assign slots = {rise_q.lo_half, fall_q.lo_half, rise_q.hi_half, fall_q.hi_half};

    AST_HOLD_RISE_HI: assert property (@(posedge fast_clk) disable iff (rst)
        (!gate && div_clk) |=> $stable(rise_q.hi_half)); // R5
    AST_HOLD_RISE_LO: assert property (@(posedge fast_clk) disable iff (rst)
        (!gate && !div_clk) |=> $stable(rise_q.lo_half)); // R5
    AST_HOLD_FALL_HI: assert property (@(posedge fast_clk_n) disable iff (rst)
        (!gate && div_clk) |=> $stable(fall_q.hi_half)); // R5
    AST_HOLD_FALL_LO: assert property (@(posedge fast_clk_n) disable iff (rst)
        (!gate && !div_clk) |=> $stable(fall_q.lo_half)); // R5
endmodule

// File: rtl/ddr_deser_word.sv
`timescale 1ns/1ps
module ddr_deser_word
    import ddr_deser_pkg::*;
(
    input  logic              div_clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] slots,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] word_d, word_q;

    always_comb word_d = slots;

    always_ff @(posedge div_clk or posedge rst) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    assign word = word_q;
endmodule

// File: rtl/ddr_deser.sv
`timescale 1ns/1ps
module ddr_deser
    import ddr_deser_pkg::*;
#(
    parameter int EN_COUNT = 2
) (
    input  logic              fast_clk,
    input  logic              fast_clk_n,
    input  logic              div_clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              en_early,
    input  logic              en_late,
    output logic [WORD_W-1:0] par_out
);
    logic              gate;
    logic [WORD_W-1:0] slots;

    ddr_deser_enable #(.EN_COUNT(EN_COUNT)) u_enable (
        .div_clk  (div_clk),
        .rst      (rst),
        .en_early (en_early),
        .en_late  (en_late),
        .gate     (gate)
    );

    ddr_deser_capture u_capture (
        .fast_clk   (fast_clk),
        .fast_clk_n (fast_clk_n),
        .div_clk    (div_clk),
        .rst        (rst),
        .ser_in     (ser_in),
        .gate       (gate),
        .slots      (slots)
    );

    ddr_deser_word u_word (
        .div_clk (div_clk),
        .rst     (rst),
        .slots   (slots),
        .word    (par_out)
    );

    AST_RESET_CLEAR: assert property (@(posedge fast_clk)
        rst |-> (par_out == '0)); // R7
endmodule

// File: tb/ddr_deser_test.sv
`timescale 1ns/1ps
module ddr_deser_test;
    localparam int CLK_PERIOD = 8;

    logic fast_clk = 1'b0;
    logic div_clk  = 1'b0;
    logic rst      = 1'b1;
    logic ser_in   = 1'b0;
    logic en_early = 1'b0;
    logic en_late  = 1'b0;
    logic fast_clk_n;
    logic [3:0] out_dual, out_single;

    assign fast_clk_n = ~fast_clk;

    ddr_deser #(.EN_COUNT(2)) uut (
        .fast_clk(fast_clk), .fast_clk_n(fast_clk_n), .div_clk(div_clk), .rst(rst),
        .ser_in(ser_in), .en_early(en_early), .en_late(en_late), .par_out(out_dual)
    );

    ddr_deser #(.EN_COUNT(1)) uut_single (
        .fast_clk(fast_clk), .fast_clk_n(fast_clk_n), .div_clk(div_clk), .rst(rst),
        .ser_in(ser_in), .en_early(en_early), .en_late(en_late), .par_out(out_single)
    );

    always #(CLK_PERIOD/2) fast_clk = ~fast_clk;

    // div_clk rises between a fast_clk rising edge and the next falling edge
    initial begin
        #(CLK_PERIOD*3/4);
        forever begin
            div_clk = 1'b1;
            #(CLK_PERIOD);
            div_clk = 1'b0;
            #(CLK_PERIOD);
        end
    end

    typedef struct {
        logic [3:0] w;
        string      tag;
    } exp_t;

    exp_t q_dual[$];
    exp_t q_single[$];
    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] held_dual   = 4'h0;
    logic [3:0] held_single = 4'h0;

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // driver: one word per divided period, expected words pushed to the scoreboard
    task automatic send_word(input logic [3:0] w, input logic ea, input logic eb,
                             input logic flip, input logic mid_ea, input string tag);
        logic eff_single;
        exp_t e;
        en_early = ea;
        en_late  = eb;
        @(posedge div_clk);
        #1;
        if (flip) en_early = mid_ea;
        eff_single = flip ? mid_ea : ea;
        ser_in = w[0];
        #4 ser_in = w[1];
        #4 ser_in = w[2];
        #4 ser_in = w[3];
        #2;
        if (ea) held_dual[1:0] = w[1:0];
        if (eb) held_dual[3:2] = w[3:2];
        if (eff_single) held_single = w;
        e.w = held_dual;   e.tag = {tag, " dual"};   q_dual.push_back(e);
        e.w = held_single; e.tag = {tag, " single"}; q_single.push_back(e);
    endtask

    // monitor: compare one word per divided-clock edge
    always begin
        exp_t e;
        @(posedge div_clk);
        #1;
        if (q_dual.size() > 0) begin
            e = q_dual.pop_front();
            check(e.tag, out_dual, e.w);
        end
        if (q_single.size() > 0) begin
            e = q_single.pop_front();
            check(e.tag, out_single, e.w);
        end
    end

    initial begin
        #(CLK_PERIOD*20000);
        n_fail++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        #2;
        check("R7 reset dual", out_dual, 4'h0);
        check("R7 reset single", out_single, 4'h0);
        #1 rst = 1'b0;

        send_word(4'hF, 1'b0, 1'b0, 1'b0, 1'b0, "R5 hold reset value");
        send_word(4'hA, 1'b1, 1'b1, 1'b0, 1'b0, "R1 pattern A");
        send_word(4'h5, 1'b1, 1'b1, 1'b0, 1'b0, "R2 pattern 5");
        send_word(4'h1, 1'b1, 1'b1, 1'b0, 1'b0, "R1 earliest bit0");
        send_word(4'h8, 1'b1, 1'b1, 1'b0, 1'b0, "R1 latest bit3");
        send_word(4'hC, 1'b1, 1'b1, 1'b0, 1'b0, "R2 pattern C");
        send_word(4'h3, 1'b1, 1'b1, 1'b0, 1'b0, "R6 pattern 3");
        send_word(4'hC, 1'b0, 1'b1, 1'b0, 1'b0, "R4 early half off");
        send_word(4'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 late ignored R4 late off");
        send_word(4'h5, 1'b1, 1'b1, 1'b1, 1'b0, "R8 mid-period early drop");
        send_word(4'h9, 1'b1, 1'b1, 1'b0, 1'b0, "R6 word after drop");
        for (int i = 0; i < 24; i++) begin
            send_word(4'((i*5 + 3) & 15), (i % 3) != 0, (i % 4) != 1,
                      (i % 7) == 2, 1'b0, "R5 mixed enables");
        end
        send_word(4'hE, 1'b1, 1'b1, 1'b0, 1'b0, "R1 before reset");
        repeat (2) @(posedge div_clk);
        #3 rst = 1'b1;
        #1;
        check("R7 async reset dual", out_dual, 4'h0);
        check("R7 async reset single", out_single, 4'h0);
        #2;
        finish_up();
    end
endmodule